// File: doc/BRIEF.md
# River-Crossing Plan Checker

This block judges, one stage per clock, whether a stream of puzzle positions forms a legal solution of the classic ferry puzzle with a man, a wolf, a goat and a cabbage. Each stage is a 4-bit snapshot giving the bank of each of the four. Bit 3 is the man, bit 2 the wolf, bit 1 the goat and bit 0 the cabbage. A 0 means the near (starting) bank and a 1 means the far bank.

A producer streams the stages with a valid qualifier. It marks the opening stage with a first strobe and the closing stage with a last strobe. The block keeps the previous stage so it can judge each move as it arrives. It records only the earliest violation, together with the stage index where it occurred. One cycle after the closing stage, it pulses `done` and presents a pass flag, a 3-bit violation code and that stage index. These three outputs hold until the next `done`.

Top module: `rcx_plan_checker`

## Requirements
- R1: Stage 0 must be 4'b0000; any other value yields code 1 (bad start) at stage 0.
- R2: Every stage after stage 0 must flip bit 3 relative to the stage before; if it does not, the result is code 3 (man stayed).
- R3: A move in which bit 3 flips and two or more of bits 2..0 also flip yields code 4 (overloaded boat).
- R4: An object bit (2..0) may flip only if, in the stage before, it equalled bit 3 (it was beside the man). Otherwise the result is code 5 (stray object).
- R5: A stage whose bits give (~b3 & b1 & (b2 | b0)) | (b3 & ~b1 & (~b2 | ~b0)) is unsafe and yields code 2.
- R6: A plan must have exactly NUM_STAGES (default 8) stages. A last strobe at any other index, or a ninth stage arriving at index NUM_STAGES, yields code 7 at that index.
- R7: The closing stage must be 4'b1111; otherwise the result is code 6 (bad end).
- R8: Only the first violating stage is reported. Within one stage, violations are ranked in this order: code 1, 3, 4, 5, 2, 7, 6.
- R9: The cycle after the closing stage is accepted, `done` is high for one cycle. At that point `pass`=1, `err_code`=0 and `err_stage`=0 for a clean plan. `pass`, `err_code` and `err_stage` hold until the next `done`.
- R10: A first strobe in the middle of a plan abandons that plan without a `done` and starts a new one. A valid stage with no plan open is ignored.
- R11: While `rst_n` is low, `done`, `pass`, `err_code` and `err_stage` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| in_valid | input | 1 | A stage is presented this cycle |
| in_first | input | 1 | This stage opens a plan (stage 0) |
| in_last | input | 1 | This stage closes the plan |
| in_state | input | 4 | Bank bits: [3] man, [2] wolf, [1] goat, [0] cabbage |
| done | output | 1 | One-cycle pulse after the closing stage |
| pass | output | 1 | Plan accepted |
| err_code | output | 3 | First violation code (0 = none) |
| err_stage | output | $clog2(NUM_STAGES+1) | Stage index of the first violation |

## Verification
Two pairs of functions can land on the same cycle.

The first pair is the first strobe and the last strobe. The bench drives a one-stage plan with both strobes high. With an all-zero stage, this must report a stage-count violation at index 0. With a non-zero stage, the ranking must let the bad-start code win.

The second pair is a move violation and an unsafe state on the same stage. Driving goat-stays/cabbage-strays into an unsafe position must report the stray object, not the unsafe state.

A restart strobe that arrives just after a recorded violation is also judged. The fresh plan must pass clean, showing the abandoned fault did not leak into it.

// File: rtl/rcx_pkg.sv
package rcx_pkg;

  localparam int BANK_W   = 4;
  localparam int OBJ_N    = 3;
  localparam int B_FERRY  = 3;
  localparam int B_WOLF   = 2;
  localparam int B_GOAT   = 1;
  localparam int B_CROP   = 0;

  typedef logic [BANK_W-1:0] bank_t;

  typedef enum logic [2:0] {
    V_NONE   = 3'd0,
    V_START  = 3'd1,
    V_UNSAFE = 3'd2,
    V_IDLE   = 3'd3,
    V_CROWD  = 3'd4,
    V_STRAY  = 3'd5,
    V_END    = 3'd6,
    V_COUNT  = 3'd7
  } viol_e;

endpackage

// File: rtl/rcx_bank_judge.sv
module rcx_bank_judge
  import rcx_pkg::*;
(
  input  bank_t cur,
  output logic  unsafe,
  output logic  at_home,
  output logic  at_goal
);

  logic ferry, wolf, goat, crop;

  always_comb begin
    ferry = cur[B_FERRY];
    wolf  = cur[B_WOLF];
    goat  = cur[B_GOAT];
    crop  = cur[B_CROP];
    // goat left with a neighbour it harms, man on the other bank
    unsafe  = (~ferry & goat & (wolf | crop)) |
              (ferry & ~goat & (~wolf | ~crop));
    at_home = (cur == '0);
    at_goal = (&cur);
  end

endmodule

// File: rtl/rcx_move_judge.sv
module rcx_move_judge
  import rcx_pkg::*;
(
  input  bank_t prev,
  input  bank_t cur,
  output logic  idle,
  output logic  crowd,
  output logic  stray
);

  logic             ferry_moved;
  logic [OBJ_N-1:0] obj_moved;
  logic [OBJ_N-1:0] obj_stray;

  assign ferry_moved = prev[B_FERRY] ^ cur[B_FERRY];

  for (genvar gi = 0; gi < OBJ_N; gi++) begin : g_obj
    assign obj_moved[gi] = prev[gi] ^ cur[gi];
    // an object may only travel when it shared the man's bank
    assign obj_stray[gi] = obj_moved[gi] & (prev[gi] ^ prev[B_FERRY]);
  end

  always_comb begin
    idle  = ~ferry_moved;
    crowd = ferry_moved & ((obj_moved[0] & obj_moved[1]) |
                           (obj_moved[0] & obj_moved[2]) |
                           (obj_moved[1] & obj_moved[2]));
    stray = |obj_stray;
  end

endmodule

// File: rtl/rcx_viol_pick.sv
module rcx_viol_pick
  import rcx_pkg::*;
#(
  parameter  int NUM_STAGES = 8,
  localparam int IDX_W      = $clog2(NUM_STAGES + 1)
) (
  input  logic [IDX_W-1:0] cur_idx,
  input  logic             in_last,
  input  logic             at_home,
  input  logic             at_goal,
  input  logic             unsafe,
  input  logic             idle,
  input  logic             crowd,
  input  logic             stray,
  output viol_e            viol
);

  localparam logic [IDX_W-1:0] IDX_OVER = IDX_W'(NUM_STAGES);
  localparam logic [IDX_W-1:0] IDX_TAIL = IDX_W'(NUM_STAGES - 1);

  logic opening, over, miscount;

  always_comb begin
    opening  = (cur_idx == '0);
    over     = (cur_idx == IDX_OVER);
    miscount = over | (in_last & (cur_idx != IDX_TAIL));
    if (opening && !at_home)        viol = V_START;
    else if (!opening && idle)      viol = V_IDLE;
    else if (!opening && crowd)     viol = V_CROWD;
    else if (!opening && stray)     viol = V_STRAY;
    else if (unsafe)                viol = V_UNSAFE;
    else if (miscount)              viol = V_COUNT;
    else if (in_last && !at_goal)   viol = V_END;
    else                            viol = V_NONE;
  end

endmodule

// File: rtl/rcx_plan_track.sv
module rcx_plan_track
  import rcx_pkg::*;
#(
  parameter  int NUM_STAGES = 8,
  localparam int IDX_W      = $clog2(NUM_STAGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_last,
  input  bank_t            in_state,
  input  viol_e            stage_viol,
  output logic [IDX_W-1:0] cur_idx,
  output bank_t            prev_state,
  output logic             done,
  output logic             pass,
  output viol_e            code,
  output logic [IDX_W-1:0] fault_stage
);

  localparam logic [IDX_W-1:0] IDX_OVER = IDX_W'(NUM_STAGES);

  logic             open_q, open_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  bank_t            prev_q, prev_d;
  viol_e            err_q, err_d, base_err;
  logic [IDX_W-1:0] eidx_q, eidx_d, base_idx;
  logic             done_q, pass_q, pass_d;
  viol_e            code_q, code_d;
  logic [IDX_W-1:0] fst_q, fst_d;
  logic             take, finish;

  always_comb begin
    take     = in_valid & (in_first | open_q);
    finish   = take & in_last;
    cur_idx  = in_first ? '0 : idx_q;
    base_err = in_first ? V_NONE : err_q;
    base_idx = in_first ? '0 : eidx_q;

    if (base_err == V_NONE && stage_viol != V_NONE) begin
      err_d  = stage_viol;
      eidx_d = cur_idx;
    end else begin
      err_d  = base_err;
      eidx_d = base_idx;
    end

    open_d = ~in_last;
    prev_d = in_state;
    idx_d  = (cur_idx == IDX_OVER) ? cur_idx : cur_idx + IDX_W'(1);

    pass_d = (err_d == V_NONE);
    code_d = err_d;
    fst_d  = eidx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      idx_q  <= '0;
      prev_q <= '0;
      err_q  <= V_NONE;
      eidx_q <= '0;
      done_q <= 1'b0;
      pass_q <= 1'b0;
      code_q <= V_NONE;
      fst_q  <= '0;
    end else begin
      done_q <= finish;
      if (take) begin
        open_q <= open_d;
        idx_q  <= idx_d;
        prev_q <= prev_d;
        err_q  <= err_d;
        eidx_q <= eidx_d;
      end
      if (finish) begin
        pass_q <= pass_d;
        code_q <= code_d;
        fst_q  <= fst_d;
      end
    end
  end

  assign prev_state  = prev_q;
  assign done        = done_q;
  assign pass        = pass_q;
  assign code        = code_q;
  assign fault_stage = fst_q;

endmodule

// File: rtl/rcx_plan_checker.sv
module rcx_plan_checker
  import rcx_pkg::*;
#(
  parameter int NUM_STAGES = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  input  logic                               in_first,
  input  logic                               in_last,
  input  logic [3:0]                         in_state,
  output logic                               done,
  output logic                               pass,
  output logic [2:0]                         err_code,
  output logic [$clog2(NUM_STAGES+1)-1:0]    err_stage
);

  localparam int IDX_W = $clog2(NUM_STAGES + 1);

  logic [IDX_W-1:0] cur_idx;
  bank_t            prev_state;
  logic             unsafe, at_home, at_goal;
  logic             idle, crowd, stray;
  viol_e            stage_viol;
  viol_e            code;

  rcx_bank_judge u_bank (
    .cur     (in_state),
    .unsafe  (unsafe),
    .at_home (at_home),
    .at_goal (at_goal)
  );

  rcx_move_judge u_move (
    .prev  (prev_state),
    .cur   (in_state),
    .idle  (idle),
    .crowd (crowd),
    .stray (stray)
  );

  rcx_viol_pick #(.NUM_STAGES(NUM_STAGES)) u_pick (
    .cur_idx (cur_idx),
    .in_last (in_last),
    .at_home (at_home),
    .at_goal (at_goal),
    .unsafe  (unsafe),
    .idle    (idle),
    .crowd   (crowd),
    .stray   (stray),
    .viol    (stage_viol)
  );

  rcx_plan_track #(.NUM_STAGES(NUM_STAGES)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_first    (in_first),
    .in_last     (in_last),
    .in_state    (in_state),
    .stage_viol  (stage_viol),
    .cur_idx     (cur_idx),
    .prev_state  (prev_state),
    .done        (done),
    .pass        (pass),
    .code        (code),
    .fault_stage (err_stage)
  );

  assign err_code = code;

endmodule

// File: rtl/rcx_plan_checker_sva.sv
module rcx_plan_checker_sva #(
  parameter int NUM_STAGES = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            in_valid,
  input logic                            in_first,
  input logic                            in_last,
  input logic [3:0]                      in_state,
  input logic                            done,
  input logic                            pass,
  input logic [2:0]                      err_code,
  input logic [$clog2(NUM_STAGES+1)-1:0] err_stage
);

  localparam int IDX_W = $clog2(NUM_STAGES + 1);

  // R9: a result appears only after a closing stage
  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_last));

  // R9: pass agrees with an empty violation code
  assert_pass_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass == (err_code == 3'd0)));

  // R9: results hold between pulses
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $past(rst_n)) |-> ($stable(pass) && $stable(err_code) && $stable(err_stage)));

  // R1: bad start is always pinned to stage 0
  assert_start_stage_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 3'd1) |-> (err_stage == '0));

  // R2: move faults never sit on stage 0
  assert_move_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (err_code == 3'd3 || err_code == 3'd4 || err_code == 3'd5)) |-> (err_stage != '0));

  // R7: a bad end is only reported on the expected final index
  assert_end_stage_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err_code == 3'd6) |-> (err_stage == IDX_W'(NUM_STAGES - 1)));

  // R11: outputs idle in reset
  always_comb begin
    if (!rst_n) begin
      assert_reset_idle_R11: assert (!done && !pass && err_code == 3'd0);
    end
  end

endmodule

bind rcx_plan_checker rcx_plan_checker_sva #(.NUM_STAGES(NUM_STAGES)) u_sva (.*);

// File: tb/sim_rcx_plan_checker.sv
`timescale 1ns/1ps
module sim_rcx_plan_checker;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_first, in_last;
  logic [3:0] in_state;
  logic       done, pass;
  logic [2:0] err_code;
  logic [3:0] err_stage;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [3:0] sol1 [8] = '{4'h0, 4'hA, 4'h2, 4'hE, 4'h4, 4'hD, 4'h5, 4'hF};
  logic [3:0] sol2 [8] = '{4'h0, 4'hA, 4'h2, 4'hB, 4'h1, 4'hD, 4'h5, 4'hF};
  logic [3:0] pl   [16];

  rcx_plan_checker #(.NUM_STAGES(8)) u0 (
    .clk, .rst_n, .in_valid, .in_first, .in_last, .in_state,
    .done, .pass, .err_code, .err_stage
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic load(input int which);
    for (int i = 0; i < 8; i++) pl[i] = (which == 1) ? sol1[i] : sol2[i];
  endtask

  task automatic stream(input int n, input bit close);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_first = (i == 0);
      in_last  = close && (i == n - 1);
      in_state = pl[i];
    end
  endtask

  task automatic run_plan(input string req, input int n, input bit ep,
                          input int ecode, input int estage);
    stream(n, 1'b1);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
    chk({req, " done"}, done, 1);
    chk({req, " result"}, {pass, err_code, err_stage}, {ep, 3'(ecode), 4'(estage)});
    @(negedge clk);
    chk({req, " done pulse"}, done, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 0; in_first = 0; in_last = 0; in_state = 0;
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {done, pass, err_code, err_stage}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_solutions();
    load(1); run_plan("R9 solution one", 8, 1, 0, 0);
    load(2); run_plan("R9 solution two", 8, 1, 0, 0);
  endtask

  task automatic t_mutants();
    load(1); pl[0] = 4'h2;                 run_plan("R1 bad start", 8, 0, 1, 0);
    load(1); pl[1] = 4'h8;                 run_plan("R5 unsafe", 8, 0, 2, 1);
    load(1); pl[2] = 4'hA;                 run_plan("R2 man stayed", 8, 0, 3, 2);
    load(1); pl[1] = 4'hE;                 run_plan("R3 overloaded", 8, 0, 4, 1);
    load(1); pl[2] = 4'h3;                 run_plan("R4 R8 stray beats unsafe", 8, 0, 5, 2);
    load(1); pl[7] = 4'hD;                 run_plan("R7 bad end", 8, 0, 6, 7);
    load(1);                               run_plan("R6 short plan", 2, 0, 7, 1);
    load(1); pl[8] = 4'h5;                 run_plan("R6 long plan", 9, 0, 7, 8);
    load(1); pl[1] = 4'h8; pl[2] = 4'h8;   run_plan("R8 first fault kept", 8, 0, 2, 1);
  endtask

  task automatic t_same_cycle();
    pl[0] = 4'h0; run_plan("R6 first+last home", 1, 0, 7, 0);
    pl[0] = 4'h5; run_plan("R8 first+last bad start", 1, 0, 1, 0);
  endtask

  task automatic t_abort();
    load(1); pl[1] = 4'h8;
    stream(3, 1'b0);
    load(2);
    run_plan("R10 restart after fault", 8, 1, 0, 0);
    // stray stage with no open plan
    @(negedge clk);
    in_valid = 1'b1; in_first = 1'b0; in_last = 1'b1; in_state = 4'h3;
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    chk("R10 orphan stage ignored", {done, pass, err_code, err_stage}, {1'b0, 1'b1, 3'd0, 4'd0});
  endtask

  initial begin
    t_reset();
    t_solutions();
    t_mutants();
    t_same_cycle();
    t_abort();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule